// File: doc/BRIEF.md
# System Register Transfer Unit

This block carries out the system-register move instructions of a 32-bit RISC core whose instructions are 16 bits wide. It takes one instruction word at a time, decodes it, and either copies one of six system registers (status word, global base, vector base, the high and low multiply-accumulate words, and the procedure return register) into a general register, pushes one of them to memory through a pre-decremented pointer, or pops the return register from memory through a post-incremented pointer. It also sets the T flag in the status word, accepts a no-operation word, and flags every other word as illegal.

The general registers live outside the block: the block reads the pointer or destination index through a combinational read port and writes back through a registered write port. Memory is reached through a request/ready port that may stretch for any number of wait cycles. A done strobe marks the cycle in which every effect of the instruction is visible; a new word is taken only while `in_ready` is high.

Top module: `sysreg_xfer_unit`

## Requirements
- R1: After reset the status word reads 0x000000F0 (interrupt mask bits 7:4 all ones, T bit 0 clear), the other five system registers hold their reset parameters (zero by default), `in_ready` is high and `done` and `mem_req` are low.
- R2: Words 0000nnnn00ss0010 (ss 00 status, 01 global base, 10 vector base) and 0000nnnn00ss1010 (ss 00 MAC high, 01 MAC low, 10 return register) write the selected register into general register n.
- R3: Words 0100nnnn00ss0011 (status, global base, vector base) and 0100nnnn00ss0010 (MAC high, MAC low, return register) first set Rn to Rn-4 (modulo 2^32) and then write the selected register to memory at the new Rn.
- R4: Word 0100mmmm00100110 reads the memory word at address Rm into the return register and then sets Rm to Rm+4 (modulo 2^32).
- R5: Word 0x0018 sets status bit 0 (T) and leaves every other bit and register unchanged; word 0x0009 changes no system register, general register or memory word.
- R6: Every other word (including ss=11 forms and the 0x0009/0x0018 patterns with nonzero bits 11:8) raises `illegal` in the same cycle as `done`, issues no memory request and changes no register or memory word.
- R7: `done` rises one cycle after acceptance for forms without memory and W+2 cycles after acceptance for memory forms whose access sees W wait cycles; it never rises for a memory form before `mem_ready` was seen.
- R8: From acceptance of a memory form until its `done`, `in_ready` is low and `in_valid` has no effect.
- R9: While `mem_req` is high and `mem_ready` low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word offered |
| in_word | input | 16 | Instruction word |
| in_ready | output | 1 | Block idle and able to take a word |
| done | output | 1 | One-cycle strobe: instruction complete |
| illegal | output | 1 | With `done`: word was not recognised |
| rf_raddr | output | RF_AW | General register read index (from the word) |
| rf_rdata | input | DATA_W | General register read data |
| rf_we | output | 1 | General register write enable |
| rf_waddr | output | RF_AW | General register write index |
| rf_wdata | output | DATA_W | General register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | DATA_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the access this cycle |
| sr_o | output | DATA_W | Status word |
| gbr_o | output | DATA_W | Global base register |
| vbr_o | output | DATA_W | Vector base register |
| mach_o | output | DATA_W | MAC high word |
| macl_o | output | DATA_W | MAC low word |
| pr_o | output | DATA_W | Return register |

## Verification
The bench sweeps every register-move and push form over all sixteen general registers and every pop over all sixteen pointers with zero to three wait cycles, and sweeps all sixteen major opcodes over every low byte for illegal words. A design that decoded the ss=11 slot or a NOP/SETT pattern with a nonzero register field as legal would touch a register or issue a request where none is allowed; one that post-decremented instead of pre-decrementing would store to the old pointer, which shows as a wrong memory index. Pointers of zero and 0xFFFFFFFC exercise wrap-around in both directions, and a word held on `in_valid` during a slow push would show up as a second decrement if the block took it.

// File: rtl/sru_pkg.sv
package sru_pkg;
   localparam int unsigned SRU_RN_W  = 4;
   localparam int unsigned SRU_NREGS = 6;

   typedef enum logic [2:0] {
      OP_BAD, OP_NOP, OP_SETT, OP_MOVE, OP_PUSH, OP_POP
   } sru_op_e;

   typedef enum logic [2:0] {
      SEL_SR   = 3'd0,
      SEL_GBR  = 3'd1,
      SEL_VBR  = 3'd2,
      SEL_MACH = 3'd3,
      SEL_MACL = 3'd4,
      SEL_PR   = 3'd5
   } sru_sel_e;

   typedef struct packed {
      sru_op_e               op;
      sru_sel_e              sel;
      logic [SRU_RN_W-1:0]   rn;
   } sru_dec_t;

   typedef enum logic {ST_IDLE, ST_MEM} sru_state_e;
endpackage

// File: rtl/sru_decode.sv
module sru_decode
   import sru_pkg::*;
(
   input  logic [15:0] word,
   output sru_dec_t    dec
);
   logic [3:0] major;
   logic [3:0] minor;
   logic [1:0] grp;
   logic       hi_clear;
   sru_sel_e   ctrl_sel;
   sru_sel_e   sys_sel;

   assign major    = word[15:12];
   assign minor    = word[3:0];
   assign grp      = word[5:4];
   assign hi_clear = (word[7:6] == 2'b00) && (grp != 2'b11);
   assign ctrl_sel = sru_sel_e'({1'b0, grp});
   assign sys_sel  = sru_sel_e'(3'(grp) + 3'd3);

   always_comb begin
      dec.op  = OP_BAD;
      dec.sel = SEL_SR;
      dec.rn  = word[11:8];
      if (word == 16'h0009) begin
         dec.op = OP_NOP;
      end else if (word == 16'h0018) begin
         dec.op = OP_SETT;
      end else if (hi_clear) begin
         if (major == 4'h0 && minor == 4'h2) begin
            dec.op  = OP_MOVE;
            dec.sel = ctrl_sel;
         end else if (major == 4'h0 && minor == 4'hA) begin
            dec.op  = OP_MOVE;
            dec.sel = sys_sel;
         end else if (major == 4'h4 && minor == 4'h3) begin
            dec.op  = OP_PUSH;
            dec.sel = ctrl_sel;
         end else if (major == 4'h4 && minor == 4'h2) begin
            dec.op  = OP_PUSH;
            dec.sel = sys_sel;
         end else if (major == 4'h4 && grp == 2'b10 && minor == 4'h6) begin
            dec.op  = OP_POP;
            dec.sel = SEL_PR;
         end
      end
   end
endmodule

// File: rtl/sru_regbank.sv
module sru_regbank
   import sru_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter logic [SRU_NREGS*DATA_W-1:0] RST_FLAT = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  sru_sel_e                      wr_sel,
   input  logic [DATA_W-1:0]             wr_data,
   input  sru_sel_e                      rd_sel,
   output logic [DATA_W-1:0]             rd_data,
   output logic [SRU_NREGS*DATA_W-1:0]   q_flat
);
   logic [DATA_W-1:0] regs_q [SRU_NREGS];

   for (genvar g = 0; g < SRU_NREGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[g] <= RST_FLAT[g*DATA_W +: DATA_W];
         end else if (wr_en && (3'(wr_sel) == 3'(g))) begin
            regs_q[g] <= wr_data;
         end
      end
      assign q_flat[g*DATA_W +: DATA_W] = regs_q[g];
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < SRU_NREGS; i++) begin
         if (3'(rd_sel) == 3'(i)) rd_data = regs_q[i];
      end
   end
endmodule

// File: rtl/sysreg_xfer_unit.sv
module sysreg_xfer_unit
   import sru_pkg::*;
#(
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       RF_AW      = 4,
   parameter int unsigned       T_BIT      = 0,
   parameter logic [DATA_W-1:0] SR_RESET   = DATA_W'(32'h0000_00F0),
   parameter logic [DATA_W-1:0] GBR_RESET  = '0,
   parameter logic [DATA_W-1:0] VBR_RESET  = '0,
   parameter logic [DATA_W-1:0] MACH_RESET = '0,
   parameter logic [DATA_W-1:0] MACL_RESET = '0,
   parameter logic [DATA_W-1:0] PR_RESET   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [15:0]       in_word,
   output logic              in_ready,
   output logic              done,
   output logic              illegal,
   output logic [RF_AW-1:0]  rf_raddr,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic              rf_we,
   output logic [RF_AW-1:0]  rf_waddr,
   output logic [DATA_W-1:0] rf_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic [DATA_W-1:0] sr_o,
   output logic [DATA_W-1:0] gbr_o,
   output logic [DATA_W-1:0] vbr_o,
   output logic [DATA_W-1:0] mach_o,
   output logic [DATA_W-1:0] macl_o,
   output logic [DATA_W-1:0] pr_o
);
   localparam int unsigned       STEP   = DATA_W / 8;
   localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);
   localparam logic [DATA_W-1:0] T_MASK = DATA_W'(1) << T_BIT;
   localparam logic [SRU_NREGS*DATA_W-1:0] RST_FLAT =
      {PR_RESET, MACL_RESET, MACH_RESET, VBR_RESET, GBR_RESET, SR_RESET};

   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_chk_width
      $error("sysreg_xfer_unit: DATA_W must be a byte multiple of at least 16");
   end
   if (RF_AW < SRU_RN_W) begin : g_chk_rf
      $error("sysreg_xfer_unit: RF_AW too narrow for the register field");
   end
   if (T_BIT >= DATA_W) begin : g_chk_tbit
      $error("sysreg_xfer_unit: T_BIT outside the status word");
   end

   sru_dec_t          dec;
   sru_state_e        state_q;
   logic              accept;
   logic              finish_any;
   logic              finish_load;
   logic [RF_AW-1:0]  rn_ext;
   logic [DATA_W-1:0] sel_val;
   logic [DATA_W-1:0] sr_val;
   logic [SRU_NREGS*DATA_W-1:0] bank_flat;
   logic              bank_we;
   sru_sel_e          bank_sel;
   logic [DATA_W-1:0] bank_wdata;

   logic              done_q;
   logic              illegal_q;
   logic              rf_we_q;
   logic [RF_AW-1:0]  rf_waddr_q;
   logic [DATA_W-1:0] rf_wdata_q;
   logic              mem_req_q;
   logic              mem_we_q;
   logic [DATA_W-1:0] mem_addr_q;
   logic [DATA_W-1:0] mem_wdata_q;
   logic [RF_AW-1:0]  ptr_idx_q;
   logic [DATA_W-1:0] ptr_next_q;

   sru_decode i_decode (
      .word (in_word),
      .dec  (dec)
   );

   if (RF_AW == SRU_RN_W) begin : g_rn_exact
      assign rn_ext = dec.rn;
   end else begin : g_rn_pad
      assign rn_ext = {{(RF_AW-SRU_RN_W){1'b0}}, dec.rn};
   end

   assign in_ready    = (state_q == ST_IDLE);
   assign accept      = in_valid && in_ready;
   assign finish_any  = (state_q == ST_MEM) && mem_ready;
   assign finish_load = finish_any && !mem_we_q;
   assign sr_val      = bank_flat[DATA_W-1:0];

   assign bank_we    = (accept && dec.op == OP_SETT) || finish_load;
   assign bank_sel   = finish_load ? SEL_PR : SEL_SR;
   assign bank_wdata = finish_load ? mem_rdata : (sr_val | T_MASK);

   sru_regbank #(
      .DATA_W   (DATA_W),
      .RST_FLAT (RST_FLAT)
   ) i_regbank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_we),
      .wr_sel  (bank_sel),
      .wr_data (bank_wdata),
      .rd_sel  (dec.sel),
      .rd_data (sel_val),
      .q_flat  (bank_flat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         done_q      <= 1'b0;
         illegal_q   <= 1'b0;
         rf_we_q     <= 1'b0;
         rf_waddr_q  <= '0;
         rf_wdata_q  <= '0;
         mem_req_q   <= 1'b0;
         mem_we_q    <= 1'b0;
         mem_addr_q  <= '0;
         mem_wdata_q <= '0;
         ptr_idx_q   <= '0;
         ptr_next_q  <= '0;
      end else begin
         done_q    <= 1'b0;
         illegal_q <= 1'b0;
         rf_we_q   <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  unique case (dec.op)
                     OP_NOP, OP_SETT: begin
                        done_q <= 1'b1;
                     end
                     OP_MOVE: begin
                        done_q     <= 1'b1;
                        rf_we_q    <= 1'b1;
                        rf_waddr_q <= rn_ext;
                        rf_wdata_q <= sel_val;
                     end
                     OP_PUSH: begin
                        rf_we_q     <= 1'b1;
                        rf_waddr_q  <= rn_ext;
                        rf_wdata_q  <= rf_rdata - STEP_V;
                        mem_req_q   <= 1'b1;
                        mem_we_q    <= 1'b1;
                        mem_addr_q  <= rf_rdata - STEP_V;
                        mem_wdata_q <= sel_val;
                        state_q     <= ST_MEM;
                     end
                     OP_POP: begin
                        mem_req_q  <= 1'b1;
                        mem_we_q   <= 1'b0;
                        mem_addr_q <= rf_rdata;
                        ptr_idx_q  <= rn_ext;
                        ptr_next_q <= rf_rdata + STEP_V;
                        state_q    <= ST_MEM;
                     end
                     default: begin
                        done_q    <= 1'b1;
                        illegal_q <= 1'b1;
                     end
                  endcase
               end
            end
            ST_MEM: begin
               if (finish_any) begin
                  mem_req_q <= 1'b0;
                  done_q    <= 1'b1;
                  state_q   <= ST_IDLE;
                  if (!mem_we_q) begin
                     rf_we_q    <= 1'b1;
                     rf_waddr_q <= ptr_idx_q;
                     rf_wdata_q <= ptr_next_q;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done      = done_q;
   assign illegal   = illegal_q;
   assign rf_raddr  = rn_ext;
   assign rf_we     = rf_we_q;
   assign rf_waddr  = rf_waddr_q;
   assign rf_wdata  = rf_wdata_q;
   assign mem_req   = mem_req_q;
   assign mem_we    = mem_we_q;
   assign mem_addr  = mem_addr_q;
   assign mem_wdata = mem_wdata_q;

   assign sr_o   = bank_flat[0*DATA_W +: DATA_W];
   assign gbr_o  = bank_flat[1*DATA_W +: DATA_W];
   assign vbr_o  = bank_flat[2*DATA_W +: DATA_W];
   assign mach_o = bank_flat[3*DATA_W +: DATA_W];
   assign macl_o = bank_flat[4*DATA_W +: DATA_W];
   assign pr_o   = bank_flat[5*DATA_W +: DATA_W];
endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              done,
   input logic              illegal,
   input logic              rf_we,
   input logic [DATA_W-1:0] rf_wdata,
   input logic              mem_req,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ready,
   input logic [DATA_W-1:0] pr_o
);
   a_r6_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> done);

   a_r6_illegal_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!rf_we && !mem_req));

   a_r7_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(mem_req)) |-> $past(mem_ready));

   a_r8_busy_while_access: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !in_ready);

   a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

   a_r4_pr_only_by_load: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pr_o) |-> (done && $past(mem_req && !mem_we && mem_ready)));

   a_r3_pointer_is_address: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && mem_req && mem_we) |-> (rf_wdata == mem_addr));

   a_r2_move_write_completes: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && !mem_req) |-> done);
endmodule

bind sysreg_xfer_unit sru_checker #(.DATA_W(DATA_W)) i_sru_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .done      (done),
   .illegal   (illegal),
   .rf_we     (rf_we),
   .rf_wdata  (rf_wdata),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ready (mem_ready),
   .pr_o      (pr_o)
);

// File: tb/test_sysreg_xfer_unit.sv
`timescale 1ns/1ps
module test_sysreg_xfer_unit;
   localparam logic [31:0] SR_RST   = 32'h0000_00F0;
   localparam logic [31:0] GBR_RST  = 32'hA5A5_0001;
   localparam logic [31:0] VBR_RST  = 32'h0000_8000;
   localparam logic [31:0] MACH_RST = 32'hDEAD_0003;
   localparam logic [31:0] MACL_RST = 32'h1234_5678;
   localparam logic [31:0] PR_RST   = 32'h0BAD_F00C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_word = 16'h0;
   logic        in_ready, done, illegal;
   logic [3:0]  rf_raddr, rf_waddr;
   logic [31:0] rf_rdata, rf_wdata;
   logic        rf_we, mem_req, mem_we, mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [31:0] sr_o, gbr_o, vbr_o, mach_o, macl_o, pr_o;

   logic [31:0] rf  [16];
   logic [31:0] mem [16];
   logic        pre_rf_we = 1'b0, pre_mem_we = 1'b0;
   logic [3:0]  pre_idx = 4'h0;
   logic [31:0] pre_val = 32'h0;
   int          wait_cfg = 0;
   int          wcnt;
   int          checks = 0;
   int          fails = 0;
   logic [31:0] exp_sys [6];

   always #5 clk = ~clk;

   sysreg_xfer_unit #(
      .DATA_W(32), .RF_AW(4), .T_BIT(0), .SR_RESET(SR_RST),
      .GBR_RESET(GBR_RST), .VBR_RESET(VBR_RST), .MACH_RESET(MACH_RST),
      .MACL_RESET(MACL_RST), .PR_RESET(PR_RST)
   ) i_sysreg_xfer_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .in_ready(in_ready), .done(done), .illegal(illegal),
      .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
      .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready), .sr_o(sr_o),
      .gbr_o(gbr_o), .vbr_o(vbr_o), .mach_o(mach_o), .macl_o(macl_o),
      .pr_o(pr_o)
   );

   assign rf_rdata  = rf[rf_raddr];
   assign mem_rdata = mem[mem_addr[5:2]];
   assign mem_ready = mem_req && (wcnt >= wait_cfg);

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) begin
            rf[i]  <= 32'h0;
            mem[i] <= 32'h0;
         end
         wcnt <= 0;
      end else begin
         if (rf_we) rf[rf_waddr] <= rf_wdata;
         else if (pre_rf_we) rf[pre_idx] <= pre_val;
         if (mem_req && mem_ready && mem_we) mem[mem_addr[5:2]] <= mem_wdata;
         else if (pre_mem_we) mem[pre_idx] <= pre_val;
         if (mem_req && !mem_ready) wcnt <= wcnt + 1;
         else wcnt <= 0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic set_rf(input logic [3:0] idx, input logic [31:0] val);
      pre_idx = idx; pre_val = val; pre_rf_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      pre_rf_we = 1'b0;
   endtask

   task automatic set_mem(input logic [3:0] idx, input logic [31:0] val);
      pre_idx = idx; pre_val = val; pre_mem_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      pre_mem_we = 1'b0;
   endtask

   task automatic run(input logic [15:0] w, input int wt, output int lat,
                      output bit ill, output bit saw_req);
      wait_cfg = wt; in_word = w; in_valid = 1'b1;
      @(posedge clk);
      lat = 0; saw_req = 1'b0;
      do begin
         @(negedge clk);
         in_valid = 1'b0;
         lat++;
         if (mem_req) saw_req = 1'b1;
      end while (!done && lat < 64);
      ill = illegal;
      @(negedge clk);
   endtask

   function automatic logic [191:0] sys_snap();
      return {sr_o, gbr_o, vbr_o, mach_o, macl_o, pr_o};
   endfunction

   function automatic logic [31:0] mem_sum();
      logic [31:0] s = 32'h0;
      for (int i = 0; i < 16; i++) s = s + (mem[i] ^ (32'h01010101 * i));
      return s;
   endfunction

   function automatic int ref_kind(input logic [15:0] w);
      if (w == 16'h0009) return 1;
      if (w == 16'h0018) return 2;
      if (w[15:12] == 4'h0 && w[7:6] == 2'b00 && w[5:4] != 2'b11 &&
          (w[3:0] == 4'h2 || w[3:0] == 4'hA)) return 3;
      if (w[15:12] == 4'h4 && w[7:6] == 2'b00 && w[5:4] != 2'b11 &&
          (w[3:0] == 4'h3 || w[3:0] == 4'h2)) return 4;
      if (w[15:12] == 4'h4 && w[7:0] == 8'h26) return 5;
      return 0;
   endfunction

   function automatic logic [15:0] move_word(input int sel, input int n);
      if (sel < 3) return {4'h0, 4'(n), 2'b00, 2'(sel), 4'h2};
      return {4'h0, 4'(n), 2'b00, 2'(sel - 3), 4'hA};
   endfunction

   function automatic logic [15:0] push_word(input int sel, input int n);
      if (sel < 3) return {4'h4, 4'(n), 2'b00, 2'(sel), 4'h3};
      return {4'h4, 4'(n), 2'b00, 2'(sel - 3), 4'h2};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int          lat;
      bit          ill, saw;
      logic [31:0] old, a;
      logic [191:0] snap;
      logic [31:0] msum, rkeep;

      exp_sys[0] = SR_RST;  exp_sys[1] = GBR_RST; exp_sys[2] = VBR_RST;
      exp_sys[3] = MACH_RST; exp_sys[4] = MACL_RST; exp_sys[5] = PR_RST;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(sr_o == 32'h0000_00F0, "R1", "status reset", sr_o, 32'h0000_00F0);
      chk(gbr_o == GBR_RST, "R1", "gbase reset", gbr_o, GBR_RST);
      chk(vbr_o == VBR_RST, "R1", "vbase reset", vbr_o, VBR_RST);
      chk(mach_o == MACH_RST, "R1", "mac high reset", mach_o, MACH_RST);
      chk(macl_o == MACL_RST, "R1", "mac low reset", macl_o, MACL_RST);
      chk(pr_o == PR_RST, "R1", "return reset", pr_o, PR_RST);
      chk(in_ready && !done && !mem_req, "R1", "handshake idle",
          {29'h0, in_ready, done, mem_req}, 32'h4);

      // R2 and R7: every move form into every register
      for (int sel = 0; sel < 6; sel++) begin
         for (int n = 0; n < 16; n++) begin
            set_rf(4'(n), ~exp_sys[sel]);
            run(move_word(sel, n), 0, lat, ill, saw);
            chk(rf[n] == exp_sys[sel], "R2", "move value", rf[n], exp_sys[sel]);
            chk(lat == 1 && !ill && !saw, "R7", "move latency", 32'(lat), 32'h1);
         end
      end

      // R5: set T, then no-operation
      snap = sys_snap();
      run(16'h0018, 0, lat, ill, saw);
      exp_sys[0] = exp_sys[0] | 32'h1;
      chk(sr_o == (SR_RST | 32'h1), "R5", "T set", sr_o, SR_RST | 32'h1);
      chk(sys_snap()[159:0] == snap[159:0] && !ill && lat == 1, "R5", "T only",
          sys_snap()[31:0], snap[31:0]);
      snap = sys_snap();
      msum = mem_sum();
      rkeep = rf[0];
      run(16'h0009, 0, lat, ill, saw);
      chk(sys_snap() == snap && mem_sum() == msum && rf[0] == rkeep && !ill && !saw,
          "R5", "nop no change", sys_snap()[31:0], snap[31:0]);

      // R3 and R7: every push form through every pointer, zero to three waits
      for (int sel = 0; sel < 6; sel++) begin
         for (int n = 0; n < 16; n++) begin
            old = (n == 0) ? 32'h0 : (32'h80 + 32'(4 * n) + 32'(sel * 64));
            set_rf(4'(n), old);
            a = old - 32'h4;
            set_mem(a[5:2], 32'hFFFF_0000 ^ exp_sys[sel] ^ 32'h5);
            run(push_word(sel, n), n % 4, lat, ill, saw);
            chk(rf[n] == a, "R3", "pointer pre-decrement", rf[n], a);
            chk(mem[a[5:2]] == exp_sys[sel], "R3", "stored value", mem[a[5:2]], exp_sys[sel]);
            chk(lat == (n % 4) + 2 && !ill, "R7", "push latency", 32'(lat), 32'((n % 4) + 2));
         end
      end

      // R4 and R7: pop through every pointer, including wrap at 0xFFFFFFFC
      for (int m = 0; m < 16; m++) begin
         old = (m == 3) ? 32'hFFFF_FFFC : (32'h40 + 32'(4 * m));
         set_rf(4'(m), old);
         set_mem(old[5:2], 32'h5000_0000 + 32'(m * 32'h111));
         run({4'h4, 4'(m), 8'h26}, 3 - (m % 4), lat, ill, saw);
         exp_sys[5] = 32'h5000_0000 + 32'(m * 32'h111);
         chk(pr_o == exp_sys[5], "R4", "return loaded", pr_o, exp_sys[5]);
         chk(rf[m] == old + 32'h4, "R4", "pointer post-increment", rf[m], old + 32'h4);
         chk(lat == (3 - (m % 4)) + 2 && !ill, "R7", "pop latency", 32'(lat),
             32'((3 - (m % 4)) + 2));
      end
      set_rf(4'd2, 32'h0);
      run(move_word(5, 2), 0, lat, ill, saw);
      chk(rf[2] == exp_sys[5], "R2", "move of loaded return", rf[2], exp_sys[5]);

      // R8: word held on in_valid during a slow push is not taken
      set_rf(4'd9, 32'h200);
      wait_cfg = 3; in_word = push_word(4, 9); in_valid = 1'b1;
      @(posedge clk);
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
         if (!done) chk(!in_ready, "R8", "busy blocks input", {31'h0, in_ready}, 32'h0);
         else in_valid = 1'b0;
      end while (!done && lat < 64);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(rf[9] == 32'h1FC, "R8", "single decrement", rf[9], 32'h1FC);
      chk(in_ready && !mem_req, "R8", "idle after", {30'h0, in_ready, mem_req}, 32'h2);

      // R6: all major opcodes times all low bytes, register field 7
      for (int hi = 0; hi < 16; hi++) begin
         for (int lo = 0; lo < 256; lo++) begin
            logic [15:0] w;
            w = {4'(hi), 4'h7, 8'(lo)};
            if (ref_kind(w) != 0) continue;
            snap = sys_snap();
            msum = mem_sum();
            rkeep = rf[7];
            run(w, 0, lat, ill, saw);
            chk(ill && lat == 1, "R6", "illegal flag", {16'h0, w}, {16'h0, w});
            chk(sys_snap() == snap && mem_sum() == msum && rf[7] == rkeep && !saw,
                "R6", "illegal no effect", {16'h0, w}, {16'h0, w});
         end
      end
      run(16'h0019, 0, lat, ill, saw);
      chk(ill, "R6", "near-miss of set T", {31'h0, ill}, 32'h1);
      chk(sr_o == exp_sys[0], "R6", "status kept", sr_o, exp_sys[0]);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule